// File: doc/BRIEF.md
# Daisy-Chained Interrupt Acknowledge Arbiter

This block arbitrates interrupt requests from a row of device controller cells that share one request line and one identifier bus. Every cell's pending request feeds a single OR, so the processor sees one interrupt line. When the processor is available it raises a root acknowledge. That acknowledge travels down the cells in their physical order. The first cell that is waiting takes it, blocks it from the cells further down, and places its own index on the shared identifier bus. Priority therefore comes only from position: index 0 sits nearest the processor and ranks highest.

A cell reacts only to a rising edge of its incoming acknowledge. It keeps a registered copy of that input and compares against it. A cell that starts to request while a lower-ranked cell owns the bus pulls its outgoing acknowledge low at once. The owner downstream then loses its acknowledge and releases the bus. It waits a parameterised back-off before it requests again. The processor-side controller withdraws the root acknowledge once nobody holds or is claiming the bus. It raises it again while requests remain, which gives the waiting cell a fresh edge to claim on.

Top module: `irqdc_arbiter`

## Requirements
- R1: `irq_line` is the OR of all cell requests: a cell counts as requesting from the clock edge after its `dev_req` bit rises until the edge after it falls. During back-off it does not count.
- R2: `ack_root` rises only on an edge where `irq_line` and `cpu_ready` were both 1. With `cpu_ready` at 0 the acknowledge stays 0 and no cell drives the identifier bus.
- R3: When the bus is free, a request raised before edge k gives `ack_root` = 1 after edge k+1. It gives `id_valid` = 1 with the owner's identifier after edge k+2.
- R4: Of the cells pending together, the one with the lowest index takes the bus. A cell never owns while a lower-index cell is requesting.
- R5: `owner` is one-hot or zero. `id_bus` carries the owner's index in binary. `id_valid` is 1 exactly when some cell owns, and only while `ack_root` is 1.
- R6: A cell claims only on a 0-to-1 change of its incoming acknowledge. A level that is already high causes no claim.
- R7: When a higher-priority cell starts to request, the lower-priority owner stops driving the bus in the same cycle. The higher cell owns four edges after its request is registered.
- R8: A lower-priority request does not disturb the current owner. When the owner drops its request, the waiting lower cell gets a rising acknowledge and owns two edges later.
- R9: A cell that loses its acknowledge while owning waits `BACKOFF_CYC` cycles without requesting. It then returns to idle and re-requests one edge later if its `dev_req` is still high.
- R10: After a synchronous reset, `irq_line`, `ack_root`, `owner`, `chain_ack` and `id_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ready | input | 1 | Processor can accept an interrupt |
| dev_req | input | N | Per-cell service request level, index 0 highest priority |
| irq_line | output | 1 | Combined interrupt request to the processor |
| ack_root | output | 1 | Processor acknowledge into the head of the chain |
| chain_ack | output | N | Outgoing acknowledge of each cell |
| owner | output | N | One-hot, cell currently driving the identifier bus |
| id_valid | output | 1 | Some cell drives the identifier bus |
| id_bus | output | ID_W | Index of the driving cell |

## Verification
The embedded properties watch on every cycle the following: the single-owner rule, that the bus is used only under a high root acknowledge, that the acknowledge rises only after a seen request, and that no cell owns past a requesting higher-priority cell. They also check that ownership begins only after a registered rising edge, and that a lost acknowledge moves the owner into back-off. Only the directed scenarios can show the exact claim latencies, which cell wins for each request pattern, and the preemption and hand-off sequences. The same holds for the length of the back-off window and for refusal holding off every cell.

// File: rtl/irqdc_pkg.sv
package irqdc_pkg;

    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_PEND = 2'd1,
        C_OWN  = 2'd2,
        C_BACK = 2'd3
    } cell_st_e;

    typedef enum logic {
        A_OFF = 1'b0,
        A_ON  = 1'b1
    } ack_st_e;

    function automatic int idw_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irqdc_cell.sv
module irqdc_cell
    import irqdc_pkg::*;
#(
    parameter int ID_W        = 2,
    parameter int IDX         = 0,
    parameter int BACKOFF_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dev_req,
    input  logic            ack_in,
    output logic            ack_out,
    output logic            req_out,
    output logic            holding,
    output logic            claim,
    output logic            drive,
    output logic [ID_W-1:0] id_out
);

    localparam int CNT_W = (BACKOFF_CYC > 1) ? $clog2(BACKOFF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BACKOFF_CYC - 1);
    localparam logic [ID_W-1:0]  MY_ID    = ID_W'(IDX);

    cell_st_e        st;
    logic            ack_q;
    logic [CNT_W-1:0] cnt;

    assign req_out = (st == C_PEND) || (st == C_OWN);
    assign holding = (st == C_OWN);
    assign claim   = (st == C_PEND) && ack_in && !ack_q;
    assign ack_out = ack_in && !req_out;
    assign drive   = (st == C_OWN) && ack_in;
    assign id_out  = MY_ID;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= C_IDLE;
            ack_q <= 1'b0;
            cnt   <= '0;
        end else begin
            ack_q <= ack_in;
            unique case (st)
                C_IDLE: if (dev_req) st <= C_PEND;
                C_PEND: begin
                    if (!dev_req)  st <= C_IDLE;
                    else if (claim) st <= C_OWN;
                end
                C_OWN: begin
                    if (!ack_in) begin
                        st  <= C_BACK;
                        cnt <= '0;
                    end else if (!dev_req) begin
                        st <= C_IDLE;
                    end
                end
                C_BACK: begin
                    if (cnt == CNT_LAST) st <= C_IDLE;
                    else                 cnt <= cnt + 1'b1;
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    // R6: ownership starts only after a registered 0-to-1 on the incoming acknowledge
    p_claim_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (st == C_OWN && $past(st) != C_OWN) |-> ($past(ack_in) && !$past(ack_q)));

    // R7: an owner whose acknowledge is pulled low moves into back-off
    p_preempt_release_r7: assert property (@(posedge clk) disable iff (rst)
        (st == C_OWN && !ack_in) |=> (st == C_BACK));

    // R9: back-off exits only toward idle, never straight to a request
    p_backoff_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (st == C_BACK) |=> (st == C_BACK || st == C_IDLE));

endmodule

// File: rtl/irqdc_ackctl.sv
module irqdc_ackctl
    import irqdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic irq_line,
    input  logic cpu_ready,
    input  logic busy,
    output logic ack_root
);

    ack_st_e st;

    assign ack_root = (st == A_ON);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= A_OFF;
        end else begin
            unique case (st)
                A_OFF: if (irq_line && cpu_ready) st <= A_ON;
                A_ON:  if (!cpu_ready || !busy)   st <= A_OFF;
                default: st <= A_OFF;
            endcase
        end
    end

endmodule

// File: rtl/irqdc_idmux.sv
module irqdc_idmux #(
    parameter int N    = 4,
    parameter int ID_W = 2
) (
    input  logic [N-1:0]           sel,
    input  logic [N-1:0][ID_W-1:0] ids,
    output logic [ID_W-1:0]        id
);

    always_comb begin
        id = '0;
        for (int i = 0; i < N; i++) begin
            id = id | (ids[i] & {ID_W{sel[i]}});
        end
    end

endmodule

// File: rtl/irqdc_arbiter.sv
module irqdc_arbiter
    import irqdc_pkg::*;
#(
    parameter int N           = 4,
    parameter int BACKOFF_CYC = 4,
    localparam int ID_W       = idw_of(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cpu_ready,
    input  logic [N-1:0]    dev_req,
    output logic            irq_line,
    output logic            ack_root,
    output logic [N-1:0]    chain_ack,
    output logic [N-1:0]    owner,
    output logic            id_valid,
    output logic [ID_W-1:0] id_bus
);

    logic [N:0]            ack_link;
    logic [N-1:0]          req_vec;
    logic [N-1:0]          hold_vec;
    logic [N-1:0]          claim_vec;
    logic [N-1:0][ID_W-1:0] id_vec;
    logic                  busy;

    assign ack_link[0] = ack_root;
    assign chain_ack   = ack_link[N:1];
    assign irq_line    = |req_vec;
    assign busy        = (|hold_vec) || (|claim_vec);
    assign id_valid    = |owner;

    irqdc_ackctl u_ackctl (
        .clk       (clk),
        .rst       (rst),
        .irq_line  (irq_line),
        .cpu_ready (cpu_ready),
        .busy      (busy),
        .ack_root  (ack_root)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        irqdc_cell #(
            .ID_W        (ID_W),
            .IDX         (i),
            .BACKOFF_CYC (BACKOFF_CYC)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .dev_req (dev_req[i]),
            .ack_in  (ack_link[i]),
            .ack_out (ack_link[i+1]),
            .req_out (req_vec[i]),
            .holding (hold_vec[i]),
            .claim   (claim_vec[i]),
            .drive   (owner[i]),
            .id_out  (id_vec[i])
        );
    end

    irqdc_idmux #(.N(N), .ID_W(ID_W)) u_idmux (
        .sel (owner),
        .ids (id_vec),
        .id  (id_bus)
    );

    // R5: never more than one cell on the identifier bus
    p_one_owner_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(owner));

    // R5: the bus is driven only under a high root acknowledge
    p_bus_needs_ack_r5: assert property (@(posedge clk) disable iff (rst)
        id_valid |-> ack_root);

    // R2: the acknowledge rises only after a seen request with the processor ready
    p_ack_needs_irq_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_root) |-> $past(irq_line && cpu_ready));

    // R4: no owner while a higher-priority cell is requesting
    for (genvar j = 1; j < N; j++) begin : g_prio
        p_prio_r4: assert property (@(posedge clk) disable iff (rst)
            owner[j] |-> !(|req_vec[j-1:0]));
    end

endmodule

// File: tb/irqdc_arbiter_tb_top.sv
`timescale 1ns/1ps
module irqdc_arbiter_tb_top;

    localparam int N    = 4;
    localparam int BK   = 4;
    localparam int ID_W = (N > 1) ? $clog2(N) : 1;
    localparam int NVEC = 6;

    // each entry: {request mask, expected winning index}
    localparam logic [N+ID_W-1:0] VEC [NVEC] = '{
        {4'b0110, 2'd1},
        {4'b1000, 2'd3},
        {4'b1111, 2'd0},
        {4'b1010, 2'd1},
        {4'b0100, 2'd2},
        {4'b1100, 2'd2}
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            cpu_ready;
    logic [N-1:0]    dev_req;
    logic            irq_line;
    logic            ack_root;
    logic [N-1:0]    chain_ack;
    logic [N-1:0]    owner;
    logic            id_valid;
    logic [ID_W-1:0] id_bus;

    int n_total = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    irqdc_arbiter #(.N(N), .BACKOFF_CYC(BK)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cpu_ready (cpu_ready),
        .dev_req   (dev_req),
        .irq_line  (irq_line),
        .ack_root  (ack_root),
        .chain_ack (chain_ack),
        .owner     (owner),
        .id_valid  (id_valid),
        .id_bus    (id_bus)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst       = 1'b1;
        dev_req   = '0;
        cpu_ready = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    // bring cell k to ownership from an idle chain (R3 timing)
    task automatic take_bus(input int k);
        dev_req[k] = 1'b1;
        tick(3);
    endtask

    initial begin
        #(8 * 200000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        // R10: reset state
        rst = 1'b1; dev_req = '0; cpu_ready = 1'b1;
        tick(2);
        chk("R10 irq_line", int'(irq_line), 0);
        chk("R10 ack_root", int'(ack_root), 0);
        chk("R10 owner", int'(owner), 0);
        chk("R10 chain_ack", int'(chain_ack), 0);
        chk("R10 id_valid", int'(id_valid), 0);
        rst = 1'b0;

        // table walk: R1, R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            dev_req = VEC[v][N+ID_W-1:ID_W];
            tick(1);
            chk("R1 irq raised", int'(irq_line), 1);
            chk("R3 no ack yet", int'(ack_root), 0);
            tick(1);
            chk("R3 ack raised", int'(ack_root), 1);
            chk("R3 bus idle in claim cycle", int'(id_valid), 0);
            tick(1);
            chk("R3 id_valid", int'(id_valid), 1);
            chk("R4 winner id", int'(id_bus), int'(VEC[v][ID_W-1:0]));
            chk("R5 owner one-hot", int'(owner), 1 << VEC[v][ID_W-1:0]);
            dev_req = '0;
            tick(2);
            chk("R1 irq dropped", int'(irq_line), 0);
        end

        // R2: refusal keeps every cell off the bus
        do_reset();
        cpu_ready = 1'b0;
        dev_req   = 4'b0101;
        tick(10);
        chk("R2 irq seen", int'(irq_line), 1);
        chk("R2 ack held low", int'(ack_root), 0);
        chk("R2 no driver", int'(id_valid), 0);
        cpu_ready = 1'b1;
        tick(2);
        chk("R2 granted after ready", int'(id_bus), 0);

        // R7 and R6: cell 0 preempts owner 2
        do_reset();
        take_bus(2);
        chk("R7 setup owner", int'(owner), 4);
        dev_req[0] = 1'b1;
        tick(1);
        chk("R7 owner released at once", int'(owner), 0);
        tick(1);
        chk("R6 steady level gives no claim", int'(id_valid), 0);
        tick(1);
        chk("R7 ack withdrawn", int'(ack_root), 0);
        tick(1);
        chk("R7 ack re-raised", int'(ack_root), 1);
        chk("R6 no owner before edge claim", int'(id_valid), 0);
        tick(1);
        chk("R7 new owner", int'(owner), 1);
        chk("R7 new id", int'(id_bus), 0);

        // R8: lower request waits, then hand-off
        do_reset();
        take_bus(0);
        dev_req[3] = 1'b1;
        tick(10);
        chk("R8 owner kept", int'(owner), 1);
        dev_req[0] = 1'b0;
        tick(1);
        chk("R8 gap cycle", int'(id_valid), 0);
        tick(1);
        chk("R8 hand-off owner", int'(owner), 8);
        chk("R8 hand-off id", int'(id_bus), 3);

        // R9: back-off after losing the acknowledge
        do_reset();
        take_bus(2);
        cpu_ready = 1'b0;
        tick(1);
        chk("R9 bus dropped on refusal", int'(id_valid), 0);
        tick(1);
        chk("R9 request withdrawn", int'(irq_line), 0);
        tick(BK);
        chk("R9 still backing off", int'(irq_line), 0);
        tick(1);
        chk("R9 request back", int'(irq_line), 1);
        cpu_ready = 1'b1;
        tick(2);
        chk("R9 regains bus", int'(owner), 4);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule